// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block is the digital control core of a safety switch that sits in the charge path between an adapter input and a battery charger. It receives comparator flags for input overvoltage, battery overvoltage, overcurrent, and the two die-temperature thresholds. It also receives a supply-low power-on flag and an active-low enable. From these inputs it decides when the pass switch may conduct, asks the gate driver for a soft-start ramp, picks fast or slow gate discharge, and drives an active-low fault flag.

All comparator and control inputs are asynchronous. They pass through a synchronizer chain before any logic uses them. After the supply comes up, the block waits through a settle interval before the first soft-start. Battery overvoltage and overcurrent are both blanked by a qualification window. Each qualified event advances a saturating count, and a full count latches the switch off. The two counts have different clear conditions. Input overvoltage is not blanked and forces fast turn-off. Over-temperature behaves as a latch with hysteresis. All time constants are parameters expressed in clock cycles.

Top module: `chg_guard_seq`

## Requirements
- R1: While the synchronized supply-low flag is high, the switch stays off. After it falls, the block waits SETTLE_CYC cycles, then requests soft-start. The switch-enable output stays 0 during that wait.
- R2: A synchronized input overvoltage flag turns the switch off on the next clock edge, with no blanking. On that same edge it sets fast_off_o to 1.
- R3: When input overvoltage clears, the switch restarts through a new soft-start: ss_req_o is 1 and sw_on_o is 0 until soft-start done is seen. If input overvoltage is present throughout the settle interval, sw_en_o never rises.
- R4: A battery overvoltage flag turns the switch off only after it has stayed high for BLANK_CYC consecutive synchronized cycles. A shorter pulse leaves the switch on and fault_n_o at 1.
- R5: An overcurrent flag is qualified by its own BLANK_CYC window in the same way. A shorter pulse is ignored.
- R6: The LOCK_EVENTS-th qualified battery overvoltage event latches the switch off. Toggling enable does not clear this latch. Only a supply-low pulse does.
- R7: The LOCK_EVENTS-th qualified overcurrent event latches the switch off. Either a supply-low pulse or a period with the enable input high clears this latch.
- R8: A high over-temperature (hot) flag turns the switch off. The switch stays off until the cool flag is seen, even after the hot flag has dropped.
- R9: While the enable input is high, the switch is off.
- R10: fault_n_o is 0 whenever any of the following is present: input overvoltage, a qualified battery overvoltage or overcurrent, over-temperature, or either lockout. Otherwise it is 1.
- R11: Turn-off caused by battery overvoltage or overcurrent leaves fast_off_o at 0, which selects slow discharge.
- R12: sw_on_o rises only after a cycle with ss_req_o high in which ss_done_i was seen.
- R13: Every asynchronous input passes through SYNC_STAGES flops. With 2 stages, a flag driven between edges reaches the outputs on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_low_i | input | 1 | Supply below power-on threshold (asynchronous) |
| en_n_i | input | 1 | Active-low enable (asynchronous) |
| in_ovp_i | input | 1 | Input overvoltage comparator (asynchronous) |
| bat_ovp_i | input | 1 | Battery overvoltage comparator (asynchronous) |
| ocp_i | input | 1 | Overcurrent comparator (asynchronous) |
| ot_hot_i | input | 1 | Die temperature above upper threshold (asynchronous) |
| ot_cool_i | input | 1 | Die temperature below lower threshold (asynchronous) |
| ss_done_i | input | 1 | Gate driver reports soft-start ramp complete |
| sw_en_o | output | 1 | Pass-switch enable |
| ss_req_o | output | 1 | Soft-start ramp request |
| sw_on_o | output | 1 | Switch reported fully on |
| fast_off_o | output | 1 | 1 = fast gate discharge, 0 = slow |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
The bench builds the block with SETTLE_CYC=10, BLANK_CYC=4, LOCK_EVENTS=16 and SYNC_STAGES=2. With these values, a full run of sixteen qualified events on each lockout channel, the clear conditions of both latches, and the hysteresis sequence all fit in roughly two thousand cycles. The short blanking window makes it cheap to place pulses one cycle below and well above qualification. The short settle interval makes it cheap to hold input overvoltage across the whole power-up wait.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;

    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,
        SW_RAMP = 2'd1,
        SW_ON   = 2'd2
    } sw_state_e;

    // Synchronized monitor flags, MSB first
    typedef struct packed {
        logic por;
        logic en_n;
        logic in_ovp;
        logic bat_ovp;
        logic ocp;
        logic ot_hot;
        logic ot_cool;
    } mon_flags_t;

    localparam int FLAG_W = $bits(mon_flags_t);

    // Reset view: supply assumed low, block disabled, no comparator active
    localparam mon_flags_t FLAG_RST = '{por: 1'b1, en_n: 1'b1, in_ovp: 1'b0,
                                        bat_ovp: 1'b0, ocp: 1'b0,
                                        ot_hot: 1'b0, ot_cool: 1'b0};

    // Blanked channels
    localparam int NCH    = 2;
    localparam int CH_BAT = 0;
    localparam int CH_OCP = 1;

    function automatic logic fault_any(input mon_flags_t s,
                                       input logic [NCH-1:0] qual,
                                       input logic hot,
                                       input logic [NCH-1:0] locked);
        return s.in_ovp | (|qual) | hot | (|locked);
    endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_o = stage[STAGES-1];

endmodule

// File: rtl/chg_blank.sv
module chg_blank #(
    parameter int BLANK_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flag_i,
    output logic fire_o,
    output logic qual_o
);

    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

    logic [CW-1:0] cnt;
    logic          qual_q;

    // One-cycle pulse on the edge at which the window completes
    assign fire_o = flag_i & ~qual_q & (cnt == LAST);
    assign qual_o = qual_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !flag_i) begin
            cnt    <= '0;
            qual_q <= 1'b0;
        end else if (!qual_q) begin
            if (fire_o) qual_q <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/chg_lock.sv
module chg_lock #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic locked_o
);

    localparam int LW = $clog2(LIMIT + 1);
    localparam logic [LW-1:0] LIMIT_V = LW'(LIMIT);

    logic [LW-1:0] cnt;

    assign locked_o = (cnt == LIMIT_V);

    always_ff @(posedge clk) begin
        if (rst || clr)               cnt <= '0;
        else if (inc && !locked_o)    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/chg_guard_seq.sv
module chg_guard_seq
    import chg_guard_pkg::*;
#(
    parameter int SETTLE_CYC  = 500000,
    parameter int BLANK_CYC   = 9000,
    parameter int LOCK_EVENTS = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic por_low_i,
    input  logic en_n_i,
    input  logic in_ovp_i,
    input  logic bat_ovp_i,
    input  logic ocp_i,
    input  logic ot_hot_i,
    input  logic ot_cool_i,
    input  logic ss_done_i,
    output logic sw_en_o,
    output logic ss_req_o,
    output logic sw_on_o,
    output logic fast_off_o,
    output logic fault_n_o
);

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    // ---------------- input synchronization ----------------
    mon_flags_t        raw_flags, s_flags;
    logic [FLAG_W-1:0] s_vec;

    assign raw_flags = '{por: por_low_i, en_n: en_n_i, in_ovp: in_ovp_i,
                         bat_ovp: bat_ovp_i, ocp: ocp_i,
                         ot_hot: ot_hot_i, ot_cool: ot_cool_i};

    chg_sync #(
        .WIDTH   (FLAG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (FLAG_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (s_vec)
    );

    assign s_flags = mon_flags_t'(s_vec);

    logic s_por, s_en_n, s_in_ovp;
    assign s_por    = s_flags.por;
    assign s_en_n   = s_flags.en_n;
    assign s_in_ovp = s_flags.in_ovp;

    // ---------------- power-up settle timer ----------------
    logic [SW-1:0] settle_cnt;
    logic          settled;

    always_ff @(posedge clk) begin
        if (rst || s_por) begin
            settle_cnt <= '0;
            settled    <= 1'b0;
        end else if (!settled) begin
            settled    <= (settle_cnt == SETTLE_LAST);
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    // ---------------- blanked channels with lockout ----------------
    logic [NCH-1:0] ch_flag, ch_fire, ch_qual, ch_clr, ch_lock;

    assign ch_flag[CH_BAT] = s_flags.bat_ovp;
    assign ch_flag[CH_OCP] = s_flags.ocp;
    assign ch_clr[CH_BAT]  = s_por;             // power cycle only
    assign ch_clr[CH_OCP]  = s_por | s_en_n;    // power cycle or disable

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chg_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk    (clk),
            .rst    (rst),
            .clr    (s_por),
            .flag_i (ch_flag[c]),
            .fire_o (ch_fire[c]),
            .qual_o (ch_qual[c])
        );
        chg_lock #(.LIMIT(LOCK_EVENTS)) u_lock (
            .clk      (clk),
            .rst      (rst),
            .clr      (ch_clr[c]),
            .inc      (ch_fire[c]),
            .locked_o (ch_lock[c])
        );
    end

    // ---------------- over-temperature hysteresis ----------------
    logic hot_q;

    always_ff @(posedge clk) begin
        if (rst || s_por)          hot_q <= 1'b0;
        else if (s_flags.ot_hot)   hot_q <= 1'b1;
        else if (s_flags.ot_cool)  hot_q <= 1'b0;
    end

    // ---------------- switch sequencer ----------------
    logic      fault, run_ok;
    sw_state_e state_q, state_d;

    assign fault  = fault_any(s_flags, ch_qual, hot_q, ch_lock);
    assign run_ok = settled & ~s_en_n & ~s_por & ~fault;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OFF:  if (run_ok) state_d = SW_RAMP;
            SW_RAMP: if (!run_ok) state_d = SW_OFF;
                     else if (ss_done_i) state_d = SW_ON;
            SW_ON:   if (!run_ok) state_d = SW_OFF;
            default: state_d = SW_OFF;
        endcase
    end

    logic fault_n_q, fast_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SW_OFF;
            fault_n_q <= 1'b1;
            fast_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            fault_n_q <= ~fault;
            fast_q    <= s_in_ovp;
        end
    end

    assign sw_en_o    = (state_q != SW_OFF);
    assign ss_req_o   = (state_q == SW_RAMP);
    assign sw_on_o    = (state_q == SW_ON);
    assign fault_n_o  = fault_n_q;
    assign fast_off_o = fast_q;

endmodule

// File: rtl/chg_guard_chk.sv
module chg_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       s_por,
    input logic       s_en_n,
    input logic       s_in_ovp,
    input logic       hot,
    input logic [1:0] locked,
    input logic       sw_en_o,
    input logic       ss_req_o,
    input logic       sw_on_o,
    input logic       fast_off_o,
    input logic       fault_n_o
);

    assert_por_off_R1: assert property (@(posedge clk) disable iff (rst)
        s_por |=> !sw_en_o);

    assert_ovp_fast_R2: assert property (@(posedge clk) disable iff (rst)
        s_in_ovp |=> (!sw_en_o && fast_off_o));

    assert_bat_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (locked[0] && !s_por) |=> locked[0]);

    assert_hot_off_R8: assert property (@(posedge clk) disable iff (rst)
        hot |=> !sw_en_o);

    assert_disable_off_R9: assert property (@(posedge clk) disable iff (rst)
        s_en_n |=> !sw_en_o);

    assert_lock_fault_R10: assert property (@(posedge clk) disable iff (rst)
        (|locked) |=> !fault_n_o);

    assert_on_after_ramp_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_on_o) |-> $past(ss_req_o));

endmodule

bind chg_guard_seq chg_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_por      (s_por),
    .s_en_n     (s_en_n),
    .s_in_ovp   (s_in_ovp),
    .hot        (hot_q),
    .locked     (ch_lock),
    .sw_en_o    (sw_en_o),
    .ss_req_o   (ss_req_o),
    .sw_on_o    (sw_on_o),
    .fast_off_o (fast_off_o),
    .fault_n_o  (fault_n_o)
);

// File: tb/sim_chg_guard_seq.sv
module sim_chg_guard_seq;

    localparam int CLK_PERIOD = 10;
    localparam int SET  = 10;
    localparam int BL   = 4;
    localparam int LOCK = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b1, en_n = 1'b0, ovp = 1'b0, bat = 1'b0, ocp = 1'b0;
    logic hot = 1'b0, cool = 1'b0, ss_done = 1'b0;
    logic sw_en, ss_req, sw_on, fast_off, fault_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_guard_seq #(
        .SETTLE_CYC (SET),
        .BLANK_CYC  (BL),
        .LOCK_EVENTS(LOCK),
        .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .por_low_i(por), .en_n_i(en_n),
        .in_ovp_i(ovp), .bat_ovp_i(bat), .ocp_i(ocp),
        .ot_hot_i(hot), .ot_cool_i(cool), .ss_done_i(ss_done),
        .sw_en_o(sw_en), .ss_req_o(ss_req), .sw_on_o(sw_on),
        .fast_off_o(fast_off), .fault_n_o(fault_n)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // ---------------- behavioural reference ----------------
    logic [6:0] pipe[$];            // {por,en_n,ovp,bat,ocp,hot,cool}
    int  m_st = 0, m_sc = 0, m_bc = 0, m_oc = 0, m_bev = 0, m_oev = 0;
    bit  m_settled = 0, m_bq = 0, m_oq = 0, m_hot = 0;
    bit  e_fault_n = 1, e_fast = 0;

    initial begin
        pipe.push_back(7'b1100000);
        pipe.push_back(7'b1100000);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_sc = 0; m_bc = 0; m_oc = 0; m_bev = 0; m_oev = 0;
            m_settled = 0; m_bq = 0; m_oq = 0; m_hot = 0;
            e_fault_n = 1; e_fast = 0;
            pipe.delete();
            pipe.push_back(7'b1100000);
            pipe.push_back(7'b1100000);
        end else begin
            logic [6:0] cur;
            bit p, dis, v, b, o, h, c, flt, ok, bf, of;
            cur = pipe[0];
            {p, dis, v, b, o, h, c} = cur;
            flt = v || m_bq || m_oq || m_hot || (m_bev == LOCK) || (m_oev == LOCK);
            ok  = m_settled && !dis && !p && !flt;
            case (m_st)
                0: if (ok) m_st = 1;
                1: if (!ok) m_st = 0; else if (ss_done) m_st = 2;
                default: if (!ok) m_st = 0;
            endcase
            e_fault_n = !flt;
            e_fast    = v;
            if (p) begin m_sc = 0; m_settled = 0; end
            else if (!m_settled) begin m_settled = (m_sc == SET - 1); m_sc++; end
            bf = b && !m_bq && (m_bc == BL - 1);
            of = o && !m_oq && (m_oc == BL - 1);
            if (p || !b) begin m_bc = 0; m_bq = 0; end
            else if (!m_bq) begin if (bf) m_bq = 1; m_bc++; end
            if (p || !o) begin m_oc = 0; m_oq = 0; end
            else if (!m_oq) begin if (of) m_oq = 1; m_oc++; end
            if (p) m_bev = 0; else if (bf && m_bev < LOCK) m_bev++;
            if (p || dis) m_oev = 0; else if (of && m_oev < LOCK) m_oev++;
            if (p) m_hot = 0; else if (h) m_hot = 1; else if (c) m_hot = 0;
            pipe.pop_front();
            pipe.push_back({por, en_n, ovp, bat, ocp, hot, cool});
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done) begin
            chk("R9 sw_en",     sw_en,    logic'(m_st != 0));
            chk("R12 ss_req",   ss_req,   logic'(m_st == 1));
            chk("R12 sw_on",    sw_on,    logic'(m_st == 2));
            chk("R10 fault_n",  fault_n,  e_fault_n);
            chk("R11 fast_off", fast_off, e_fast);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic bat_event(input bit first);
        bat = 1'b1; wait_n(10);
        if (first) begin
            chk("R4 bat long off", sw_en, 1'b0);
            chk("R11 bat slow", fast_off, 1'b0);
        end
        bat = 1'b0; wait_n(12);
    endtask

    task automatic ocp_event(input bit first);
        ocp = 1'b1; wait_n(10);
        if (first) begin
            chk("R5 ocp long off", sw_en, 1'b0);
            chk("R11 ocp slow", fast_off, 1'b0);
        end
        ocp = 1'b0; wait_n(12);
    endtask

    initial begin
        wait_n(3);
        chk("R1 reset sw_en", sw_en, 1'b0);
        chk("R10 reset fault_n", fault_n, 1'b1);
        rst = 1'b0;
        // power-up settle
        por = 1'b0; wait_n(5);
        chk("R1 settle off", sw_en, 1'b0);
        wait_n(15);
        chk("R12 ramp req", ss_req, 1'b1);
        chk("R12 not on yet", sw_on, 1'b0);
        ss_done = 1'b1; wait_n(2);
        chk("R12 on", sw_on, 1'b1);
        // input overvoltage, sync latency
        ovp = 1'b1; wait_n(2);
        chk("R13 two-flop latency", sw_en, 1'b1);
        wait_n(1);
        chk("R2 ovp off", sw_en, 1'b0);
        chk("R2 fast", fast_off, 1'b1);
        chk("R10 ovp fault", fault_n, 1'b0);
        ss_done = 1'b0; ovp = 1'b0; wait_n(5);
        chk("R3 restart ramp", ss_req, 1'b1);
        chk("R11 fast cleared", fast_off, 1'b0);
        ss_done = 1'b1; wait_n(3);
        // short pulses
        bat = 1'b1; wait_n(2); bat = 1'b0; wait_n(10);
        chk("R4 short bat ignored", sw_on, 1'b1);
        chk("R4 short bat no fault", fault_n, 1'b1);
        ocp = 1'b1; wait_n(2); ocp = 1'b0; wait_n(10);
        chk("R5 short ocp ignored", sw_on, 1'b1);
        // battery lockout
        for (int i = 0; i < LOCK; i++) bat_event(i == 0);
        chk("R6 bat lock", sw_en, 1'b0);
        chk("R10 lock fault", fault_n, 1'b0);
        en_n = 1'b1; wait_n(4); en_n = 1'b0; wait_n(15);
        chk("R6 enable no clear", sw_en, 1'b0);
        por = 1'b1; wait_n(4); por = 1'b0; wait_n(20);
        chk("R6 power cycle clears", sw_on, 1'b1);
        // overcurrent lockout
        for (int i = 0; i < LOCK; i++) ocp_event(i == 0);
        chk("R7 ocp lock", sw_en, 1'b0);
        en_n = 1'b1; wait_n(4);
        chk("R9 disabled", sw_en, 1'b0);
        en_n = 1'b0; wait_n(10);
        chk("R7 enable clears", sw_on, 1'b1);
        // over-temperature hysteresis
        hot = 1'b1; wait_n(3); hot = 1'b0; wait_n(10);
        chk("R8 hold until cool", sw_en, 1'b0);
        chk("R10 hot fault", fault_n, 1'b0);
        cool = 1'b1; wait_n(8);
        chk("R8 resume", sw_on, 1'b1);
        cool = 1'b0; wait_n(2);
        // overvoltage across the settle interval
        por = 1'b1; ovp = 1'b1; wait_n(4);
        por = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 30; i++) begin
                wait_n(1);
                if (sw_en) seen = 1'b1;
            end
            chk("R3 never enabled", seen, 1'b0);
        end
        ovp = 1'b0; wait_n(20);
        chk("R3 on after ovp clears", sw_on, 1'b1);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule